// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits between a bank of timer channels and the interrupt controller. Each timer channel raises a one-cycle fire event. The router turns that event into activity on one of a fixed set of interrupt output lines. Each timer has its own configuration: a target line number, a select between level and edge signalling, and an enable. A global enable also applies to every timer. Level events are recorded in a status register that software clears by writing ones to it. Edge events only pulse the line.

A global legacy-replacement mode takes over two fixed lines, line 0 and line 8, for timers 0 and 1. While the mode is on, the router blocks the interrupts that come from an external legacy periodic timer and from a real-time clock, and tells the legacy timer to stop through an enable output. The router always tracks the real-time-clock input level, so that line 8 shows the correct level again when legacy mode ends. Lines 16 and above are active-low; every other line is active-high.

All outputs are registered. An input change is visible on the outputs one clock after the edge that samples it.

Top module: `irq_router_top`

## Requirements
- R1: After reset the status register reads zero, `pit_en_o` is 1, lines 0..15 are low and lines 16..31 are high.
- R2: When an enabled level-mode timer fires, its status bit is set and its routed line becomes active. Both hold until that bit is cleared.
- R3: When an enabled edge-mode timer fires, its status bit is zero and its routed line is active for exactly one cycle.
- R4: Lines with index 16 or higher are active-low: they are driven 0 when active and 1 when idle. Lines 0..15 are driven 1 when active.
- R5: A status write clears every status bit where the write data has a 1. Bit n of the write data belongs to timer n. A 0 bit in the write data leaves that status bit unchanged, and a cleared bit deasserts the line it drove.
- R6: When a timer's enable is low, or the global enable is low, that timer's status bit is cleared and its line is idle.
- R7: In legacy mode, timer 0 drives line 0 and timer 1 drives line 8, whatever their route fields hold. Timers 2 and above keep using their route fields.
- R8: In legacy mode, `pit_en_o` is 0 and the legacy-timer and RTC inputs have no effect on lines 0 and 8.
- R9: Outside legacy mode, `pit_irq_i` drives line 0 and `rtc_irq_i` drives line 8, one cycle later. Either input is ORed with any timer routed to the same line.
- R10: When legacy mode ends, `pit_en_o` returns to 1 and line 8 takes the last `rtc_irq_i` level sampled, including levels sampled while legacy mode was on.
- R11: Within one cycle, a disable wins over a fire, and a fire wins over a status-clear write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en_i | input | 1 | Global interrupt enable |
| legacy_i | input | 1 | Legacy-replacement mode select |
| tmr_en_i | input | NUM_TIMERS | Per-timer enable |
| trig_level_i | input | NUM_TIMERS | Per-timer trigger select: 1 = level, 0 = edge |
| route_i | input | NUM_TIMERS*ROUTE_W | Per-timer target line; timer n uses bits [n*ROUTE_W +: ROUTE_W] |
| fire_i | input | NUM_TIMERS | One-cycle fire event from each timer channel |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdata_i | input | STAT_W | Status write data; a 1 in bit n clears timer n |
| pit_irq_i | input | 1 | Interrupt from the legacy periodic timer |
| rtc_irq_i | input | 1 | Interrupt from the real-time clock |
| irq_o | output | NUM_LINES | Interrupt output lines |
| status_o | output | STAT_W | Status register, one bit per timer, upper bits zero |
| pit_en_o | output | 1 | Enable to the legacy periodic timer |

## Verification
The bench targets routing under legacy mode. A design that ignores the override would leave timer 0 on its programmed line instead of line 0. A design that overrides every timer would move timer 2 as well. The bench also sets the RTC input while legacy mode is on and then ends the mode. A design that records the RTC level only outside legacy mode would show a stale line 8. Other targets are the active-low lines, where an inverted polarity shows as a line stuck wrong at reset, and the same-cycle collisions between fire, clear and disable, where a wrong priority loses a level event or keeps a status bit on a disabled timer.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    // Per-timer event state: latched level status and a one-cycle edge pulse
    typedef struct packed {
        logic stat;
        logic pulse;
    } slot_state_t;

    // Legacy gate state: registered mode and sampled external levels
    typedef struct packed {
        logic legacy;
        logic rtc_lvl;
        logic pit_lvl;
    } leg_state_t;

    // Drive level for a line given whether it is active
    function automatic logic drive_level(input logic active, input logic low_true);
        return low_true ? ~active : active;
    endfunction

endpackage

// File: rtl/tmr_event_slot.sv
module tmr_event_slot
    import irq_router_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic level_i,
    input  logic fire_i,
    input  logic clear_i,
    output logic stat_o,
    output logic pulse_o
);

    slot_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (!enable_i) begin
            st_d.stat = 1'b0;
        end else if (fire_i) begin
            if (level_i) begin
                st_d.stat = 1'b1;
            end else begin
                st_d.stat  = 1'b0;
                st_d.pulse = 1'b1;
            end
        end else if (clear_i) begin
            st_d.stat = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o  = st_q.stat;
    assign pulse_o = st_q.pulse;

endmodule

// File: rtl/legacy_gate.sv
module legacy_gate
    import irq_router_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic legacy_i,
    input  logic pit_irq_i,
    input  logic rtc_irq_i,
    output logic legacy_q_o,
    output logic pit_pass_o,
    output logic rtc_pass_o,
    output logic pit_en_o
);

    leg_state_t lg_d, lg_q;

    always_comb begin
        lg_d         = lg_q;
        lg_d.legacy  = legacy_i;
        lg_d.rtc_lvl = rtc_irq_i;   // recorded in both modes
        lg_d.pit_lvl = pit_irq_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lg_q <= '0;
        end else begin
            lg_q <= lg_d;
        end
    end

    assign legacy_q_o = lg_q.legacy;
    assign pit_pass_o = ~lg_q.legacy & lg_q.pit_lvl;
    assign rtc_pass_o = ~lg_q.legacy & lg_q.rtc_lvl;
    assign pit_en_o   = ~lg_q.legacy;

endmodule

// File: rtl/line_mapper.sv
module line_mapper
    import irq_router_pkg::*;
#(
    parameter int NUM_TIMERS = 4,
    parameter int NUM_LINES  = 32,
    parameter int INV_BASE   = 16,
    parameter int LEG_LINE_A = 0,
    parameter int LEG_LINE_B = 8,
    localparam int ROUTE_W   = $clog2(NUM_LINES)
) (
    input  logic                          legacy_q_i,
    input  logic [NUM_TIMERS*ROUTE_W-1:0] route_i,
    input  logic [NUM_TIMERS-1:0]         src_i,
    input  logic                          pit_pass_i,
    input  logic                          rtc_pass_i,
    output logic [NUM_LINES-1:0]          irq_o
);

    logic [NUM_LINES-1:0] active;

    always_comb begin
        active = '0;
        for (int t = 0; t < NUM_TIMERS; t++) begin
            logic [ROUTE_W-1:0] eff;
            eff = route_i[t*ROUTE_W +: ROUTE_W];
            if (legacy_q_i && t == 0) eff = ROUTE_W'(LEG_LINE_A);
            if (legacy_q_i && t == 1) eff = ROUTE_W'(LEG_LINE_B);
            if (src_i[t]) active[eff] = 1'b1;
        end
        active[LEG_LINE_A] = active[LEG_LINE_A] | pit_pass_i;
        active[LEG_LINE_B] = active[LEG_LINE_B] | rtc_pass_i;
    end

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_pol
        if (k >= INV_BASE) begin : g_low
            assign irq_o[k] = drive_level(active[k], 1'b1);
        end else begin : g_high
            assign irq_o[k] = drive_level(active[k], 1'b0);
        end
    end

endmodule

// File: rtl/irq_router_top.sv
module irq_router_top
    import irq_router_pkg::*;
#(
    parameter int NUM_TIMERS = 4,
    parameter int NUM_LINES  = 32,
    parameter int STAT_W     = 32,
    parameter int INV_BASE   = 16,
    parameter int LEG_LINE_A = 0,
    parameter int LEG_LINE_B = 8,
    localparam int ROUTE_W   = $clog2(NUM_LINES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          glb_en_i,
    input  logic                          legacy_i,
    input  logic [NUM_TIMERS-1:0]         tmr_en_i,
    input  logic [NUM_TIMERS-1:0]         trig_level_i,
    input  logic [NUM_TIMERS*ROUTE_W-1:0] route_i,
    input  logic [NUM_TIMERS-1:0]         fire_i,
    input  logic                          stat_wr_i,
    input  logic [STAT_W-1:0]             stat_wdata_i,
    input  logic                          pit_irq_i,
    input  logic                          rtc_irq_i,
    output logic [NUM_LINES-1:0]          irq_o,
    output logic [STAT_W-1:0]             status_o,
    output logic                          pit_en_o
);

    logic [NUM_TIMERS-1:0] stat_vec;
    logic [NUM_TIMERS-1:0] pulse_vec;
    logic                  legacy_q;
    logic                  pit_pass;
    logic                  rtc_pass;
    logic                  unused_wdata;

    assign unused_wdata = ^stat_wdata_i;

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_slot
        tmr_event_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable_i (tmr_en_i[t] & glb_en_i),
            .level_i  (trig_level_i[t]),
            .fire_i   (fire_i[t]),
            .clear_i  (stat_wr_i & stat_wdata_i[t]),
            .stat_o   (stat_vec[t]),
            .pulse_o  (pulse_vec[t])
        );
    end

    legacy_gate u_leg (
        .clk        (clk),
        .rst_n      (rst_n),
        .legacy_i   (legacy_i),
        .pit_irq_i  (pit_irq_i),
        .rtc_irq_i  (rtc_irq_i),
        .legacy_q_o (legacy_q),
        .pit_pass_o (pit_pass),
        .rtc_pass_o (rtc_pass),
        .pit_en_o   (pit_en_o)
    );

    line_mapper #(
        .NUM_TIMERS (NUM_TIMERS),
        .NUM_LINES  (NUM_LINES),
        .INV_BASE   (INV_BASE),
        .LEG_LINE_A (LEG_LINE_A),
        .LEG_LINE_B (LEG_LINE_B)
    ) u_map (
        .legacy_q_i (legacy_q),
        .route_i    (route_i),
        .src_i      (stat_vec | pulse_vec),
        .pit_pass_i (pit_pass),
        .rtc_pass_i (rtc_pass),
        .irq_o      (irq_o)
    );

    assign status_o = STAT_W'(stat_vec);

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int NUM_TIMERS = 4,
    parameter int STAT_W     = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  glb_en_i,
    input logic                  legacy_i,
    input logic [NUM_TIMERS-1:0] tmr_en_i,
    input logic [NUM_TIMERS-1:0] trig_level_i,
    input logic [NUM_TIMERS-1:0] fire_i,
    input logic                  stat_wr_i,
    input logic [STAT_W-1:0]     stat_wdata_i,
    input logic [STAT_W-1:0]     status_o,
    input logic                  pit_en_o
);

    logic [NUM_TIMERS-1:0] lvl_fire;
    logic [NUM_TIMERS-1:0] edg_fire;
    assign lvl_fire = fire_i & tmr_en_i & trig_level_i & {NUM_TIMERS{glb_en_i}};
    assign edg_fire = fire_i & tmr_en_i & ~trig_level_i & {NUM_TIMERS{glb_en_i}};

    // R2
    level_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_fire != '0 |=> (status_o[NUM_TIMERS-1:0] & $past(lvl_fire)) == $past(lvl_fire));

    // R3
    edge_no_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edg_fire != '0 |=> (status_o[NUM_TIMERS-1:0] & $past(edg_fire)) == '0);

    // R5
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr_i && fire_i == '0) |=>
            (status_o[NUM_TIMERS-1:0] & $past(stat_wdata_i[NUM_TIMERS-1:0])) == '0);

    // R6
    global_off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en_i |=> status_o == '0);

    // R8
    legacy_stops_pit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_i |=> !pit_en_o);

    // R10
    legacy_exit_pit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !legacy_i |=> pit_en_o);

endmodule

bind irq_router_top irq_router_chk #(
    .NUM_TIMERS (NUM_TIMERS),
    .STAT_W     (STAT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .glb_en_i     (glb_en_i),
    .legacy_i     (legacy_i),
    .tmr_en_i     (tmr_en_i),
    .trig_level_i (trig_level_i),
    .fire_i       (fire_i),
    .stat_wr_i    (stat_wr_i),
    .stat_wdata_i (stat_wdata_i),
    .status_o     (status_o),
    .pit_en_o     (pit_en_o)
);

// File: tb/irq_router_top_tb.sv
`timescale 1ns/1ps
module irq_router_top_tb;

    localparam int NT = 4;
    localparam int RW = 5;
    localparam logic [31:0] IDLE = 32'hFFFF_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          glb_en = 1'b0;
    logic          legacy = 1'b0;
    logic [NT-1:0] tmr_en = '0;
    logic [NT-1:0] trig_lvl = '0;
    logic [NT*RW-1:0] route = '0;
    logic [NT-1:0] fire = '0;
    logic          stat_wr = 1'b0;
    logic [31:0]   stat_wdata = '0;
    logic          pit_irq = 1'b0;
    logic          rtc_irq = 1'b0;
    logic [31:0]   irq;
    logic [31:0]   status;
    logic          pit_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_router_top u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .glb_en_i     (glb_en),
        .legacy_i     (legacy),
        .tmr_en_i     (tmr_en),
        .trig_level_i (trig_lvl),
        .route_i      (route),
        .fire_i       (fire),
        .stat_wr_i    (stat_wr),
        .stat_wdata_i (stat_wdata),
        .pit_irq_i    (pit_irq),
        .rtc_irq_i    (rtc_irq),
        .irq_o        (irq),
        .status_o     (status),
        .pit_en_o     (pit_en)
    );

    function automatic logic [31:0] lines(input logic [31:0] active);
        return IDLE ^ active;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic set_route(input int t, input int line);
        route[t*RW +: RW] = RW'(line);
    endtask

    task automatic fire_once(input logic [NT-1:0] m);
        fire = m;
        cyc();
        fire = '0;
    endtask

    task automatic clear_all();
        stat_wr = 1'b1; stat_wdata = 32'hFFFF_FFFF;
        cyc();
        stat_wr = 1'b0; stat_wdata = '0;
    endtask

    task automatic t_reset();
        chk("R1 status", status, 32'h0);
        chk("R1 lines", irq, IDLE);
        chk("R1 pit_en", {31'h0, pit_en}, 32'h1);
    endtask

    task automatic t_level_w1c();
        glb_en = 1; tmr_en = '1; trig_lvl = 4'b1101;
        set_route(0, 3); set_route(1, 20); set_route(2, 17); set_route(3, 5);
        fire_once(4'b0001);
        chk("R2 status set", status, 32'h1);
        chk("R2 line3", irq, lines(32'h8));
        cyc(); cyc();
        chk("R2 held", irq, lines(32'h8));
        stat_wr = 1; stat_wdata = 32'h0000_0002;
        cyc(); stat_wr = 0; stat_wdata = '0;
        chk("R5 zero bit keeps", status, 32'h1);
        stat_wr = 1; stat_wdata = 32'h0000_0001;
        cyc(); stat_wr = 0; stat_wdata = '0;
        chk("R5 cleared status", status, 32'h0);
        chk("R5 line idle", irq, IDLE);
    endtask

    task automatic t_edge_inv();
        fire_once(4'b0010);
        chk("R3 status clear", status, 32'h0);
        chk("R3 R4 pulse low", irq, lines(32'h0010_0000));
        cyc();
        chk("R3 pulse ends", irq, IDLE);
        fire_once(4'b0100);
        chk("R4 level line17 low", irq, lines(32'h0002_0000));
        chk("R2 status bit2", status, 32'h4);
    endtask

    task automatic t_disable();
        tmr_en = 4'b1011;
        cyc();
        chk("R6 timer off clears", status, 32'h0);
        chk("R6 line idle", irq, IDLE);
        tmr_en = '1;
        fire_once(4'b1000);
        chk("R2 timer3 set", status, 32'h8);
        glb_en = 0;
        cyc();
        chk("R6 global off clears", status, 32'h0);
        chk("R6 global off idle", irq, IDLE);
        glb_en = 1;
        cyc();
    endtask

    task automatic t_priority();
        stat_wr = 1; stat_wdata = 32'h1;
        fire_once(4'b0001);
        stat_wr = 0; stat_wdata = '0;
        chk("R11 fire beats clear", status, 32'h1);
        tmr_en = 4'b1110;
        fire_once(4'b0001);
        chk("R11 disable beats fire", status, 32'h0);
        tmr_en = '1;
        cyc();
    endtask

    task automatic t_passthru();
        pit_irq = 1;
        cyc();
        chk("R9 pit to line0", irq, lines(32'h1));
        pit_irq = 0; rtc_irq = 1;
        cyc();
        chk("R9 rtc to line8", irq, lines(32'h100));
        rtc_irq = 0;
        cyc();
        chk("R9 both idle", irq, IDLE);
    endtask

    task automatic t_legacy();
        legacy = 1; pit_irq = 1; rtc_irq = 1;
        cyc();
        chk("R8 pit_en low", {31'h0, pit_en}, 32'h0);
        chk("R8 inputs blocked", irq, IDLE);
        set_route(2, 9);
        trig_lvl = 4'b0111;
        fire_once(4'b0111);
        chk("R7 legacy routing", irq, lines(32'h0000_0301));
        clear_all();
        chk("R7 cleared", irq, IDLE);
        pit_irq = 0;
        legacy = 0;
        cyc();
        chk("R10 pit_en back", {31'h0, pit_en}, 32'h1);
        chk("R10 rtc restored", irq, lines(32'h100));
        rtc_irq = 0;
        cyc();
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(); cyc();
        t_reset();
        rst_n = 1;
        cyc();
        t_reset();
        t_level_w1c();
        t_edge_inv();
        t_disable();
        t_priority();
        t_passthru();
        t_legacy();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule